// File: doc/BRIEF.md
# Direct-Mapped Address Translation Buffer with Access Rights

This block turns a 32-bit effective address into a physical address for one side of a processor, either the fetch side or the load/store side, chosen by a parameter. Pages are 8 KiB. The low 13 bits of the address pass through unchanged. Bits 31:13 form the page number. The lower bits of the page number select one set, and every way of that set is compared at once. Each entry has two words. The tag word holds the page number and a valid bit. The translation word holds the physical page number and a set of access flags.

Software owns the contents. It writes either word of any entry through a configuration write port and reads any word back through a combinational read port. After a miss, software reads the captured faulting address, refills the entry, and retries the access. A lookup finishes in the same cycle it is presented. It reports one of four outcomes:

- a translated address,
- a miss, when no valid tag matches,
- a permission fault, when a tag matches but the access is not allowed,
- the flat address, when translation is switched off.

The cache-inhibit flag of the matching entry is reported alongside the result.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid and every configuration word reads as zero. `fault_ea_o` is zero. A requested lookup with translation on reports a miss.
- R2: With `xlat_en_i` low, `lk_pa_o` equals `lk_va_i`, and `lk_miss_o`, `lk_fault_o` and `lk_ci_o` are all low.
- R3: The set index is `lk_va_i[13 +: log2(SETS)]`. On a hit, `lk_pa_o` is the entry's physical page number in bits 31:13 followed by `lk_va_i[12:0]`.
- R4: A requested lookup with translation on reports `lk_miss_o` when no way of the indexed set has valid bit 1 and a page number equal to `lk_va_i[31:13]`. Miss and fault are never high together.
- R5: A hit without the needed right raises `lk_fault_o`. On the load/store side, the flags are user read bit 6, user write bit 7, supervisor read bit 8 and supervisor write bit 9, selected by `lk_sup_i` and `lk_wr_i`. On the fetch side, the flags are supervisor execute bit 6 and user execute bit 7.
- R6: `lk_ci_o` equals bit 1 of the hit entry's translation word while translating, and is low otherwise.
- R7: A configuration address is {word select, way, set}. Word select 0 (bit 6 by default) is the tag word, read back as page number in 31:13 and valid in bit 0. Word select 1 is the translation word, read back as page number in 31:13 and flags in 9:0. All other bits read zero. Writes to a way index at or above WAYS are dropped, and reads of such a way return zero.
- R8: Writing zero to both words of an entry removes it from every later lookup.
- R9: A configuration write lands at the clock edge. A lookup in the same cycle sees the old contents, and the next cycle sees the new ones.
- R10: At each edge where a requested lookup misses or faults, `fault_ea_o` captures `lk_va_i`. At all other edges it holds its value.
- R11: When several ways of a set match, the lowest-numbered way supplies the translation.
- R12: With `lk_req_i` low, neither miss nor fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_en_i | input | 1 | Translation enable |
| lk_req_i | input | 1 | Lookup is a real access |
| lk_sup_i | input | 1 | Access is made in supervisor mode |
| lk_wr_i | input | 1 | Access is a store (ignored on the fetch side) |
| lk_va_i | input | 32 | Effective address |
| lk_pa_o | output | 32 | Physical address |
| lk_miss_o | output | 1 | No matching entry |
| lk_fault_o | output | 1 | Entry matched, right missing |
| lk_ci_o | output | 1 | Cache inhibit of hit entry |
| fault_ea_o | output | 32 | Last missing or faulting address |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_waddr_i | input | CFG_AW | Configuration write address |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_raddr_i | input | CFG_AW | Configuration read address |
| cfg_rdata_o | output | 32 | Configuration read data |

## Verification
A software refill and a lookup to the same entry can arrive in the same cycle. The lookup must then see the pre-write contents. The directed part writes a tag and then a translation word while a lookup of the page being written is held on the inputs. The expected sequence is a miss, then a fault produced by the still-empty translation word, then a clean translation. The random phase forces further collisions by drawing write addresses and lookup addresses from the same small pool of pages. A behavioural model applies writes only after it has judged that cycle's outputs, and every output is compared against it on each clock.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned PG_OFS_W = 13;
  localparam int unsigned PN_W     = ADDR_W - PG_OFS_W;
  localparam int unsigned FLG_W    = 10;

  // flag positions in the translation word
  localparam int unsigned FLG_CI = 1;
  localparam int unsigned FLG_UR = 6;
  localparam int unsigned FLG_UW = 7;
  localparam int unsigned FLG_SR = 8;
  localparam int unsigned FLG_SW = 9;
  localparam int unsigned FLG_SX = 6;
  localparam int unsigned FLG_UX = 7;

  typedef struct packed {
    logic [PN_W-1:0] vpn;
    logic            vld;
  } tag_t;

  typedef struct packed {
    logic [PN_W-1:0]  ppn;
    logic [FLG_W-1:0] flg;
  } xlt_t;
endpackage

// File: rtl/tlb_store.sv
`timescale 1ns/1ps
module tlb_store
  import tlb_pkg::*;
#(
  parameter int unsigned SETS   = 32,
  parameter int unsigned WAYS   = 1,
  parameter int unsigned SET_W  = $clog2(SETS),
  parameter int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  parameter int unsigned CFG_AW = 1 + WAY_W + SET_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CFG_AW-1:0]    waddr_i,
  input  logic [ADDR_W-1:0]    wdata_i,
  input  logic [CFG_AW-1:0]    raddr_i,
  output logic [ADDR_W-1:0]    rdata_o,
  input  logic [SET_W-1:0]     lk_set_i,
  output tag_t [WAYS-1:0]      tags_o,
  output xlt_t [WAYS-1:0]      xlts_o
);
  logic             w_tr, r_tr;
  logic [WAY_W-1:0] w_way, r_way;
  logic [SET_W-1:0] w_set, r_set;

  assign {w_tr, w_way, w_set} = waddr_i;
  assign {r_tr, r_way, r_set} = raddr_i;

  tag_t [WAYS-1:0] rd_tag;
  xlt_t [WAYS-1:0] rd_xlt;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[PG_OFS_W-1:FLG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tag_t tag_q [SETS];
    xlt_t xlt_q [SETS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) begin
          tag_q[s] <= '0;
          xlt_q[s] <= '0;
        end
      end else if (we_i && (w_way == WAY_W'(w))) begin
        if (w_tr) xlt_q[w_set] <= xlt_t'{ppn: wdata_i[ADDR_W-1:PG_OFS_W], flg: wdata_i[FLG_W-1:0]};
        else      tag_q[w_set] <= tag_t'{vpn: wdata_i[ADDR_W-1:PG_OFS_W], vld: wdata_i[0]};
      end
    end

    assign tags_o[w] = tag_q[lk_set_i];
    assign xlts_o[w] = xlt_q[lk_set_i];
    assign rd_tag[w] = tag_q[r_set];
    assign rd_xlt[w] = xlt_q[r_set];
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (r_way == WAY_W'(w)) begin
        if (r_tr) rdata_o = {rd_xlt[w].ppn, {(PG_OFS_W-FLG_W){1'b0}}, rd_xlt[w].flg};
        else      rdata_o = {rd_tag[w].vpn, {(PG_OFS_W-1){1'b0}}, rd_tag[w].vld};
      end
    end
  end

  AST_WR_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !w_tr && (int'(w_way) < int'(WAYS)) && (waddr_i == raddr_i))
    |=> (raddr_i != $past(raddr_i)) || (rdata_o[ADDR_W-1:PG_OFS_W] == $past(wdata_i[ADDR_W-1:PG_OFS_W]))); // R7
endmodule

// File: rtl/tlb_hit_sel.sv
`timescale 1ns/1ps
module tlb_hit_sel
  import tlb_pkg::*;
#(
  parameter int unsigned WAYS = 1
) (
  input  tag_t [WAYS-1:0] tags_i,
  input  xlt_t [WAYS-1:0] xlts_i,
  input  logic [PN_W-1:0] vpn_i,
  output logic            hit_o,
  output xlt_t            xlt_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = tags_i[w].vld && (tags_i[w].vpn == vpn_i);
  end

  // lowest way wins: scan downward, last write sticks
  always_comb begin
    xlt_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) xlt_o = xlts_i[w];
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/tlb_perm_chk.sv
`timescale 1ns/1ps
module tlb_perm_chk
  import tlb_pkg::*;
#(
  parameter int unsigned INSN_SIDE = 0
) (
  input  logic [FLG_W-1:0] flg_i,
  input  logic             sup_i,
  input  logic             wr_i,
  output logic             ok_o
);
  if (INSN_SIDE != 0) begin : g_fetch
    assign ok_o = sup_i ? flg_i[FLG_SX] : flg_i[FLG_UX];
    logic unused_in;
    assign unused_in = wr_i ^ (^flg_i[FLG_W-1:FLG_UX+1]) ^ (^flg_i[FLG_SX-1:0]);
  end else begin : g_data
    assign ok_o = sup_i ? (wr_i ? flg_i[FLG_SW] : flg_i[FLG_SR])
                        : (wr_i ? flg_i[FLG_UW] : flg_i[FLG_UR]);
    logic unused_in;
    assign unused_in = ^flg_i[FLG_UR-1:0];
  end
endmodule

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned INSN_SIDE = 0,
  parameter int unsigned SETS      = 32,
  parameter int unsigned WAYS      = 1,
  parameter int unsigned SET_W     = $clog2(SETS),
  parameter int unsigned WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  parameter int unsigned CFG_AW    = 1 + WAY_W + SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xlat_en_i,
  input  logic              lk_req_i,
  input  logic              lk_sup_i,
  input  logic              lk_wr_i,
  input  logic [31:0]       lk_va_i,
  output logic [31:0]       lk_pa_o,
  output logic              lk_miss_o,
  output logic              lk_fault_o,
  output logic              lk_ci_o,
  output logic [31:0]       fault_ea_o,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_waddr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [CFG_AW-1:0] cfg_raddr_i,
  output logic [31:0]       cfg_rdata_o
);
  logic [SET_W-1:0] lk_set;
  tag_t [WAYS-1:0]  tags;
  xlt_t [WAYS-1:0]  xlts;
  xlt_t             hit_xlt;
  logic             hit, perm_ok, xlate;
  logic [31:0]      fea_q;

  assign lk_set = lk_va_i[PG_OFS_W +: SET_W];

  tlb_store #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W), .CFG_AW(CFG_AW)
  ) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .waddr_i  (cfg_waddr_i),
    .wdata_i  (cfg_wdata_i),
    .raddr_i  (cfg_raddr_i),
    .rdata_o  (cfg_rdata_o),
    .lk_set_i (lk_set),
    .tags_o   (tags),
    .xlts_o   (xlts)
  );

  tlb_hit_sel #(.WAYS(WAYS)) i_hit_sel (
    .tags_i (tags),
    .xlts_i (xlts),
    .vpn_i  (lk_va_i[ADDR_W-1:PG_OFS_W]),
    .hit_o  (hit),
    .xlt_o  (hit_xlt)
  );

  tlb_perm_chk #(.INSN_SIDE(INSN_SIDE)) i_perm (
    .flg_i (hit_xlt.flg),
    .sup_i (lk_sup_i),
    .wr_i  (lk_wr_i),
    .ok_o  (perm_ok)
  );

  assign xlate      = xlat_en_i && hit;
  assign lk_pa_o    = xlate ? {hit_xlt.ppn, lk_va_i[PG_OFS_W-1:0]} : lk_va_i;
  assign lk_ci_o    = xlate && hit_xlt.flg[FLG_CI];
  assign lk_miss_o  = lk_req_i && xlat_en_i && !hit;
  assign lk_fault_o = lk_req_i && xlate && !perm_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       fea_q <= '0;
    else if (lk_miss_o || lk_fault_o)  fea_q <= lk_va_i;
  end
  assign fault_ea_o = fea_q;

  AST_MISS_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_miss_o && lk_fault_o)); // R4
  AST_BYPASS_FLAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xlat_en_i |-> (lk_pa_o == lk_va_i) && !lk_miss_o && !lk_fault_o && !lk_ci_o); // R2
  AST_OFS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_pa_o[PG_OFS_W-1:0] == lk_va_i[PG_OFS_W-1:0]); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |-> !lk_miss_o && !lk_fault_o); // R12
  AST_EA_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_miss_o || lk_fault_o) |=> fault_ea_o == $past(lk_va_i)); // R10
  AST_EA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_miss_o || lk_fault_o) |=> $stable(fault_ea_o)); // R10
endmodule

// File: tb/test_xlat_tlb.sv
`timescale 1ns/1ps
module test_xlat_tlb;
  localparam int SETS = 32;
  localparam int AW   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic en, req, sup, wr, we;
  logic [31:0] va, wdata;
  logic [AW-1:0] waddr, raddr;
  logic [1:0][31:0] pa, fea, rdata;
  logic [1:0] miss, fault, ci;

  xlat_tlb #(.INSN_SIDE(0), .SETS(SETS), .WAYS(2)) i_xlat_tlb (
    .clk_i(clk), .rst_ni(rst_n), .xlat_en_i(en), .lk_req_i(req), .lk_sup_i(sup),
    .lk_wr_i(wr), .lk_va_i(va), .lk_pa_o(pa[0]), .lk_miss_o(miss[0]),
    .lk_fault_o(fault[0]), .lk_ci_o(ci[0]), .fault_ea_o(fea[0]), .cfg_we_i(we),
    .cfg_waddr_i(waddr), .cfg_wdata_i(wdata), .cfg_raddr_i(raddr), .cfg_rdata_o(rdata[0])
  );

  xlat_tlb #(.INSN_SIDE(1), .SETS(SETS), .WAYS(1)) i_xlat_tlb_insn (
    .clk_i(clk), .rst_ni(rst_n), .xlat_en_i(en), .lk_req_i(req), .lk_sup_i(sup),
    .lk_wr_i(wr), .lk_va_i(va), .lk_pa_o(pa[1]), .lk_miss_o(miss[1]),
    .lk_fault_o(fault[1]), .lk_ci_o(ci[1]), .fault_ea_o(fea[1]), .cfg_we_i(we),
    .cfg_waddr_i(waddr), .cfg_wdata_i(wdata), .cfg_raddr_i(raddr), .cfg_rdata_o(rdata[1])
  );

  logic [31:0] mt [2][2][SETS];
  logic [31:0] mx [2][2][SETS];
  logic [31:0] mea [2];
  int nways [2] = '{2, 1};
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // reference: judge this cycle's outputs, then apply what the edge will do
  task automatic model_cycle();
    for (int i = 0; i < 2; i++) begin
      logic [4:0] s;
      logic [31:0] x, e_pa, e_rd;
      bit hit, ok, e_miss, e_fault, e_ci;
      int hw;
      s = va[17:13];
      hit = 1'b0;
      hw = 0;
      for (int w = 0; w < nways[i]; w++)
        if (!hit && mt[i][w][s][0] && (mt[i][w][s][31:13] == va[31:13])) begin
          hit = 1'b1;
          hw = w;
        end
      x = mx[i][hw][s];
      if (i == 1) ok = sup ? x[6] : x[7];
      else        ok = sup ? (wr ? x[9] : x[8]) : (wr ? x[7] : x[6]);
      e_pa    = (en && hit) ? {x[31:13], va[12:0]} : va;
      e_miss  = req && en && !hit;
      e_fault = req && en && hit && !ok;
      e_ci    = en && hit && x[1];
      if (int'(raddr[5]) >= nways[i]) e_rd = '0;
      else e_rd = raddr[6] ? mx[i][raddr[5]][raddr[4:0]] : mt[i][raddr[5]][raddr[4:0]];
      chk(en ? "R3" : "R2", $sformatf("pa inst%0d", i), pa[i], e_pa);
      chk("R4", $sformatf("miss inst%0d", i), {31'b0, miss[i]}, {31'b0, e_miss});
      chk("R5", $sformatf("fault inst%0d", i), {31'b0, fault[i]}, {31'b0, e_fault});
      chk("R6", $sformatf("ci inst%0d", i), {31'b0, ci[i]}, {31'b0, e_ci});
      chk("R7", $sformatf("readback inst%0d", i), rdata[i], e_rd);
      chk("R10", $sformatf("fault ea inst%0d", i), fea[i], mea[i]);
      if (e_miss || e_fault) mea[i] = va;
      if (we && (int'(waddr[5]) < nways[i])) begin
        if (waddr[6]) mx[i][waddr[5]][waddr[4:0]] = {wdata[31:13], 3'b0, wdata[9:0]};
        else          mt[i][waddr[5]][waddr[4:0]] = {wdata[31:13], 12'b0, wdata[0]};
      end
    end
  endtask

  task automatic tick();
    #1;
    model_cycle();
    @(negedge clk);
  endtask

  function automatic logic [18:0] pick_page(input int k);
    case (k)
      0: return 19'h00010;
      1: return 19'h00030;
      2: return 19'h7FFF3;
      3: return 19'h00005;
      default: return 19'($urandom);
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 2; i++) begin
      mea[i] = '0;
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < SETS; s++) begin
          mt[i][w][s] = '0;
          mx[i][w][s] = '0;
        end
    end
    en = 0; req = 0; sup = 0; wr = 0; we = 0;
    va = '0; wdata = '0; waddr = '0; raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    en = 1; req = 1; va = 32'h0002_0123; raddr = 7'h10;
    #1;
    chk("R1", "miss after reset", {31'b0, miss[0]}, 32'd1);
    chk("R1", "readback after reset", rdata[0], 32'h0);
    chk("R1", "fault ea after reset", fea[0], 32'h0);
    tick();

    // R9 write and lookup in the same cycle
    we = 1; waddr = 7'h10; wdata = 32'h0002_0001; va = 32'h0002_0040; sup = 1; wr = 0;
    #1;
    chk("R9", "lookup during tag write", {31'b0, miss[0]}, 32'd1);
    tick();
    waddr = 7'h50; wdata = 32'h0157_8102;
    #1;
    chk("R9", "fault on old translate word", {31'b0, fault[0]}, 32'd1);
    chk("R9", "pa from old translate word", pa[0], 32'h0000_0040);
    tick();
    we = 0;
    #1;
    chk("R9", "pa after both writes", pa[0], 32'h0157_8040);
    chk("R6", "ci of hit entry", {31'b0, ci[0]}, 32'd1);
    chk("R5", "supervisor read allowed", {31'b0, fault[0]}, 32'd0);
    chk("R5", "fetch side supervisor exec denied", {31'b0, fault[1]}, 32'd1);
    tick();

    // R5 denied rights
    wr = 1;
    #1;
    chk("R5", "supervisor write denied", {31'b0, fault[0]}, 32'd1);
    tick();
    sup = 0; wr = 0;
    #1;
    chk("R5", "user read denied", {31'b0, fault[0]}, 32'd1);
    tick();

    // R11 second way with the same page
    sup = 1; we = 1; waddr = 7'h30; wdata = 32'h0002_0001;
    tick();
    waddr = 7'h70; wdata = 32'h0022_23C2;
    tick();
    we = 0; raddr = 7'h30;
    #1;
    chk("R11", "lowest way supplies translation", pa[0], 32'h0157_8040);
    chk("R7", "way 1 tag readback", rdata[0], 32'h0002_0001);
    chk("R7", "out of range way reads zero", rdata[1], 32'h0);
    tick();

    // R8 invalidate way 0
    we = 1; waddr = 7'h10; wdata = 32'h0;
    tick();
    waddr = 7'h50;
    tick();
    we = 0; raddr = 7'h50;
    #1;
    chk("R8", "way 1 used after invalidate", pa[0], 32'h0022_2040);
    chk("R8", "fetch side misses after invalidate", {31'b0, miss[1]}, 32'd1);
    chk("R8", "invalidated word reads zero", rdata[0], 32'h0);
    tick();

    // R12 no request
    req = 0; va = 32'h1234_5678;
    #1;
    chk("R12", "no miss without request", {31'b0, miss[0]}, 32'd0);
    tick();

    // R10 capture
    req = 1;
    #1;
    chk("R4", "unmapped page misses", {31'b0, miss[0]}, 32'd1);
    tick();
    req = 0; va = 32'h0;
    #1;
    chk("R10", "captured faulting address", fea[0], 32'h1234_5678);
    tick();

    // R2 flat mode
    en = 0; req = 1; va = 32'hDEAD_BEEF;
    #1;
    chk("R2", "flat address", pa[0], 32'hDEAD_BEEF);
    chk("R2", "no miss when flat", {31'b0, miss[0]}, 32'd0);
    tick();

    // mixed traffic, writes and lookups on a shared page pool
    for (int n = 0; n < 4000; n++) begin
      logic [18:0] vp, wp;
      vp = pick_page($urandom_range(0, 4));
      wp = pick_page($urandom_range(0, 4));
      we = ($urandom_range(0, 3) == 0);
      waddr = {1'($urandom), 1'($urandom), wp[4:0]};
      wdata = ($urandom_range(0, 7) == 0) ? 32'h0 : {wp, 13'($urandom)};
      raddr = 7'($urandom);
      va = {vp, 13'($urandom)};
      en = ($urandom_range(0, 4) != 0);
      req = ($urandom_range(0, 5) != 0);
      sup = 1'($urandom);
      wr = 1'($urandom);
      tick();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule